// File: doc/BRIEF.md
# Retriggerable Immediate Reset One-Shot

This block turns an active-high detect input, such as a card-presence switch, into a reset request. A rising edge on the filtered input starts a reset pulse at once, with no setup delay. A later rising edge seen while the pulse is still running reloads the timer, so the request ends only after a full timeout has passed with no new edge.

Falling edges never produce a reset. After the input drops, a debounce window is opened. Any bounce back to high inside that window is absorbed and does not count as a new insertion. The window is restarted by every further falling edge. Short glitches are removed before all of this by a filter that needs a run of equal samples.

Time is counted in ticks of a one-cycle-wide millisecond strobe. The pulse length, the debounce length and the filter depth are parameters. After power-on reset the first sampled input level becomes the reference, so an input that is already high does not fire a pulse.

Top module: `card_rst_oneshot`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 0. After release, the first sampled level of `det_in` becomes the reference, and an input that is already high at startup does not assert `rst_req`.
- R2: The filtered level follows `det_in` only after FILT_LEN consecutive clock samples of the new value. A shorter excursion is ignored, and a filtered rise and a filtered fall are never flagged in the same cycle.
- R3: A filtered rise while the block is armed (reference low) asserts `rst_req` in the next cycle. This is FILT_LEN+1 clock edges after `det_in` first samples high.
- R4: `rst_req` stays 1 until PULSE_MS ticks of `ms_tick` have occurred after the last trigger cycle. It falls in the cycle after that tick, so it only ever falls right after a tick.
- R5: A new armed rising edge during a running pulse reloads the full PULSE_MS count.
- R6: A filtered fall never asserts `rst_req` and does not shorten a pulse that is running.
- R7: After a filtered fall, rises are ignored until DEB_MS ticks have occurred since the most recent filtered fall. Each new filtered fall restarts that window.
- R8: When the debounce window expires, the block becomes armed if the filtered level is low. If the level is high, that level becomes the reference and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| det_in | input | 1 | Synchronized active-high detect input |
| rst_req | output | 1 | Active-high reset pulse request |

## Verification
On every cycle the assertions check four things. The filtered level moves only toward a value the input already held, and rise and fall flags never occur together. The request rises only after an armed filtered rise and falls only right after a tick. Neither a fall nor any rise during a debounce window can start the request. Other behaviour spans many ticks, and only the bench scenarios can show it. These are the pulse length, the fact that a retrigger really extends the pulse beyond the first timeout, the restarting debounce window, and the two outcomes when the window expires.

// File: rtl/card_rst_pkg.sv
package card_rst_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HIGH  = 2'd2,
    ST_DEB   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/crst_glitch_filter.sv
module crst_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic seeded,
  output logic seed_stb,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          seeded_q, seeded_d;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seed_q, seed_d;
  logic          rise_q, rise_d;
  logic          fall_q, fall_d;

  always_comb begin
    seeded_d = seeded_q;
    level_d  = level_q;
    cnt_d    = cnt_q;
    seed_d   = 1'b0;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    if (!seeded_q) begin
      seeded_d = 1'b1;
      level_d  = din;
      cnt_d    = '0;
      seed_d   = 1'b1;
    end else if (din != level_q) begin
      if (cnt_q == LAST) begin
        level_d = din;
        cnt_d   = '0;
        rise_d  = din;
        fall_d  = ~din;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seeded_q <= 1'b0;
      level_q  <= 1'b0;
      cnt_q    <= '0;
      seed_q   <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      seeded_q <= seeded_d;
      level_q  <= level_d;
      cnt_q    <= cnt_d;
      seed_q   <= seed_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
    end
  end

  assign level    = level_q;
  assign seeded   = seeded_q;
  assign seed_stb = seed_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;
endmodule

// File: rtl/crst_tick_counter.sv
module crst_tick_counter #(
  parameter int LOAD_VAL = 210
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic is_zero
);
  localparam int CW = $clog2(LOAD_VAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign is_zero = (cnt_q == '0);
  assign cnt_en  = load | (tick & ~is_zero);

  always_comb begin
    if (load) cnt_d = CW'(LOAD_VAL);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crst_edge_ctrl.sv
module crst_edge_ctrl
  import card_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed_stb,
  input  logic       level,
  input  logic       rise_stb,
  input  logic       fall_stb,
  input  logic       deb_zero,
  output logic       trig,
  output logic       deb_load,
  output ctl_state_e state
);
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    trig     = 1'b0;
    deb_load = 1'b0;
    unique case (st_q)
      ST_INIT: begin
        if (seed_stb) st_d = level ? ST_HIGH : ST_ARMED;
      end
      ST_ARMED: begin
        if (rise_stb) begin
          trig = 1'b1;
          st_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (fall_stb) begin
          deb_load = 1'b1;
          st_d     = ST_DEB;
        end
      end
      ST_DEB: begin
        if (fall_stb)      deb_load = 1'b1;
        else if (deb_zero) st_d = level ? ST_HIGH : ST_ARMED;
      end
      default: st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_INIT;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/card_rst_oneshot.sv
module card_rst_oneshot
  import card_rst_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int PULSE_MS = 210,
  parameter int DEB_MS   = 210
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic det_in,
  output logic rst_req
);
  logic       filt_level, filt_seeded, seed_stb, rise_stb, fall_stb;
  logic       trig, deb_load, deb_zero, pulse_zero;
  ctl_state_e ctl_state;

  crst_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(det_in),
    .level(filt_level), .seeded(filt_seeded), .seed_stb(seed_stb),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  crst_edge_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .seed_stb(seed_stb), .level(filt_level),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .deb_zero(deb_zero),
    .trig(trig), .deb_load(deb_load), .state(ctl_state)
  );

  crst_tick_counter #(.LOAD_VAL(DEB_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .load(deb_load), .tick(ms_tick), .is_zero(deb_zero)
  );

  crst_tick_counter #(.LOAD_VAL(PULSE_MS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load(trig), .tick(ms_tick), .is_zero(pulse_zero)
  );

  assign rst_req = ~pulse_zero;
endmodule

// File: rtl/card_rst_oneshot_chk.sv
module card_rst_oneshot_chk
  import card_rst_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       det_in,
  input logic       rst_req,
  input logic       level,
  input logic       seeded,
  input logic       rise_stb,
  input logic       fall_stb,
  input ctl_state_e state
);
  // R2: filtered level only moves to a value the input held the cycle before
  assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seeded) && !$stable(level)) |-> ($past(det_in) == level));

  // R2: rise and fall flags are exclusive
  assert_edge_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  // R3: armed rise raises the request next cycle
  assert_armed_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && state == ST_ARMED) |=> rst_req);

  // R3: the request only rises after an armed rise
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(rise_stb && state == ST_ARMED));

  // R4: the request only ends right after a millisecond tick
  assert_end_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> $past(ms_tick));

  // R6: a falling edge cannot start the request
  assert_fall_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && !rst_req) |=> !rst_req);

  // R7: nothing starts the request inside the debounce window
  assert_deb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEB && !rst_req) |=> !rst_req);
endmodule

bind card_rst_oneshot card_rst_oneshot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .det_in(det_in),
  .rst_req(rst_req), .level(filt_level), .seeded(filt_seeded),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .state(ctl_state)
);

// File: tb/card_rst_oneshot_test.sv
module card_rst_oneshot_test;
  localparam int FILT_LEN = 4;
  localparam int PULSE_MS = 10;
  localparam int DEB_MS   = 3;
  localparam int TICK_DIV = 10;
  localparam int NSTEP    = 14;

  // step vector: {input level, hold cycles[7:0], expected rst_req}
  localparam logic [9:0] STEPS [NSTEP] = '{
    {1'b0, 8'd20, 1'b0},  // idle armed
    {1'b1, 8'd2,  1'b0},  // glitch high, too short
    {1'b0, 8'd20, 1'b0},  // glitch rejected
    {1'b1, 8'd8,  1'b1},  // rise triggers
    {1'b1, 8'd30, 1'b1},  // pulse running
    {1'b1, 8'd80, 1'b0},  // pulse expired
    {1'b0, 8'd10, 1'b0},  // fall, no pulse
    {1'b1, 8'd6,  1'b0},  // bounce inside window ignored
    {1'b0, 8'd40, 1'b0},  // fall restarts window, then armed
    {1'b1, 8'd8,  1'b1},  // new rise triggers
    {1'b0, 8'd40, 1'b1},  // fall does not cut pulse
    {1'b1, 8'd20, 1'b1},  // retrigger
    {1'b1, 8'd60, 1'b1},  // beyond first timeout, still on
    {1'b1, 8'd40, 1'b0}   // retriggered pulse expired
  };

  logic clk, rst_n, ms_tick, det_in, rst_req;
  int   n_checks, n_fail, tick_cnt;
  bit   done;

  card_rst_oneshot #(.FILT_LEN(FILT_LEN), .PULSE_MS(PULSE_MS), .DEB_MS(DEB_MS)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .det_in(det_in), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    ms_tick  = 1'b0;
    tick_cnt = 0;
  end
  always @(negedge clk) begin
    tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    ms_tick  = (tick_cnt == 0);
  end

  function automatic string step_tag(int i);
    case (i)
      1, 2:    return "R2";
      3:       return "R3";
      4, 5:    return "R4";
      6:       return "R6";
      7:       return "R7";
      8, 9:    return "R8";
      10:      return "R6";
      11, 12:  return "R5";
      13:      return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_req=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hold(input logic lvl, input int cyc);
    det_in = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n  = 1'b0;
    det_in = lvl;
    repeat (3) @(negedge clk);
    check(rst_req, 1'b0, "R1");
    rst_n = 1'b1;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 0;
    rst_n    = 1'b0;
    det_in   = 1'b0;
    do_reset(1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      hold(STEPS[i][9], int'(STEPS[i][8:1]));
      check(rst_req, STEPS[i][0], step_tag(i));
    end

    // R3: exact latency, low after FILT_LEN edges, high after FILT_LEN+1
    hold(1'b0, 60);
    hold(1'b1, FILT_LEN);
    check(rst_req, 1'b0, "R3");
    hold(1'b1, 1);
    check(rst_req, 1'b1, "R3");

    // R1: reset in the middle of a pulse clears it
    do_reset(1'b1);
    // R1: input already high at startup gives no pulse
    hold(1'b1, 30);
    check(rst_req, 1'b0, "R1");
    // R8: window expires with level low, then a rise triggers
    hold(1'b0, 60);
    check(rst_req, 1'b0, "R8");
    hold(1'b1, 8);
    check(rst_req, 1'b1, "R8");
    hold(1'b1, 120);
    check(rst_req, 1'b0, "R4");
    // R8: return high inside window, stay high past it: no pulse
    hold(1'b0, 10);
    hold(1'b1, 50);
    check(rst_req, 1'b0, "R8");
    hold(1'b1, 50);
    check(rst_req, 1'b0, "R8");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule